// File: doc/BRIEF.md
# Disciplined Nanosecond Time-of-Day Counter

This block holds a time of day as whole seconds plus nanoseconds with a binary fraction. It advances on a fixed tick, derived from the core clock at a fixed number of cycles per tick, with a nominal rate of 1024 ticks per second. An outside agent steers the counter through a write port. That agent supplies a phase offset, a time-constant exponent and a frequency offset. The counter never steps the time by the whole offset. On each tick it adds a geometric share of the remaining phase error, and it adds the frequency correction in equal per-tick portions that sum to one second's worth.

A read port returns a timestamp with sub-tick resolution. The stored tick value is extended by the cycles counted since that tick, scaled at the nominal rate. Each result is clamped so that a read never reports less than the read before it. Corrections written between ticks wait for the next tick boundary. A frequency change alters the per-tick increment only when the seconds field next rolls over.

Top module: `disc_tod_counter`

## Requirements
- R1: While reset is high and in the cycle after it, rd_valid is 0. A read issued in the first cycle after reset returns 0 s, 0 ns, fraction 0.
- R2: A tick occurs once every TICK_CYCLES clock cycles, the first at the TICK_CYCLES-th rising edge after reset is released. Between ticks the stored time is unchanged. With no corrections, each tick adds (10^9 << FRAC_W) / TICKS_PER_SEC in nanosecond units with FRAC_W fraction bits.
- R3: The nanoseconds field stays below 1,000,000,000. Reaching that value subtracts it and increments the seconds field by one.
- R4: wr_freq is a signed frequency offset in nanoseconds per second with FRAC_W fraction bits. It is adopted at the first tick after it is registered. The per-tick increment becomes nominal + (offset >>> log2(TICKS_PER_SEC)), and it changes only at the tick on which the seconds field increments.
- R5: On every tick, the step q >>> shift (arithmetic shift) is added to the time and subtracted from the residual phase q.
- R6: A write of wr_phase (signed whole nanoseconds) with wr_shift replaces the residual and the exponent at the first tick after it is registered. That tick already applies the step of the new value.
- R7: rd_req high in a cycle gives rd_valid high one cycle later. The value is the stored time plus c × (nominal increment / TICK_CYCLES), where c is the number of cycles since the last tick (0 in the first cycle after a tick), normalised by R3.
- R8: A returned timestamp is never smaller than the previously returned one. A smaller candidate is replaced by the previous result.
- R9: When a negative phase step exceeds the increment, the tick advance is clamped to zero and the time does not move backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_phase_en | input | 1 | Load phase offset and exponent |
| wr_phase | input | PHASE_W | Signed phase offset, whole ns |
| wr_shift | input | SHIFT_W | Time-constant exponent |
| wr_freq_en | input | 1 | Load frequency offset |
| wr_freq | input | FREQ_W | Signed frequency offset, ns/s with FRAC_W fraction bits |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read result valid |
| rd_sec | output | 32 | Seconds of read result |
| rd_ns | output | 30 | Nanoseconds of read result |
| rd_frac | output | FRAC_W | Fraction of a nanosecond |

## Verification
A read result is due on the falling edge that follows the rising edge at which rd_req was sampled. The bench checks it there against a model advanced at the same rising edge, and the model takes its interpolation count from the state before that edge. Writes are registered on the edge where they are presented and act at the following tick, so the model captures them after it evaluates any tick on that edge. Frequency effects show up one seconds rollover later, so the run spans more than two simulated seconds and reads straddle each rollover.

// File: rtl/dtod_pkg.sv
package dtod_pkg;
    typedef logic [63:0]        fx_t;
    typedef logic signed [63:0] sfx_t;

    typedef struct packed {
        logic [31:0] sec;
        fx_t         nsf;
    } stamp_t;

    localparam fx_t NS_PER_SEC = 64'd1000000000;

    function automatic fx_t nominal_inc(input int frac_w, input int tps);
        return (NS_PER_SEC << frac_w) / fx_t'(tps);
    endfunction

    function automatic stamp_t carry_sec(input stamp_t s, input fx_t wrap);
        stamp_t r;
        r = s;
        if (r.nsf >= wrap) begin
            r.nsf = r.nsf - wrap;
            r.sec = r.sec + 32'd1;
        end
        return r;
    endfunction
endpackage

// File: rtl/dtod_tick_gen.sv
module dtod_tick_gen #(
    parameter int TICK_CYCLES = 8,
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/dtod_slew_unit.sv
module dtod_slew_unit
    import dtod_pkg::*;
#(
    parameter int FRAC_W  = 16,
    parameter int PHASE_W = 29,
    parameter int SHIFT_W = 5,
    parameter int FREQ_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      wr_phase_en,
    input  logic signed [PHASE_W-1:0] wr_phase,
    input  logic [SHIFT_W-1:0]        wr_shift,
    input  logic                      wr_freq_en,
    input  logic signed [FREQ_W-1:0]  wr_freq,
    output sfx_t                      step,
    output sfx_t                      freq_eff
);
    logic               ph_pend, fr_pend;
    sfx_t               ph_new, fr_new, q, fr;
    logic [SHIFT_W-1:0] sh_new, sh;
    sfx_t               q_eff;
    logic [SHIFT_W-1:0] sh_eff;

    always_comb begin
        q_eff    = ph_pend ? ph_new : q;
        sh_eff   = ph_pend ? sh_new : sh;
        step     = q_eff >>> sh_eff;
        freq_eff = fr_pend ? fr_new : fr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_pend <= 1'b0;
            fr_pend <= 1'b0;
            ph_new  <= '0;
            fr_new  <= '0;
            sh_new  <= '0;
            sh      <= '0;
            q       <= '0;
            fr      <= '0;
        end else begin
            if (tick) begin
                q       <= q_eff - step;
                sh      <= sh_eff;
                fr      <= freq_eff;
                ph_pend <= 1'b0;
                fr_pend <= 1'b0;
            end
            if (wr_phase_en) begin
                ph_pend <= 1'b1;
                ph_new  <= sfx_t'(wr_phase) <<< FRAC_W;
                sh_new  <= wr_shift;
            end
            if (wr_freq_en) begin
                fr_pend <= 1'b1;
                fr_new  <= sfx_t'(wr_freq);
            end
        end
    end

    p_q_decay_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ph_pend && !q[63]) |=> (!q[63] && q <= $past(q)));
    p_q_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> $stable(q));
endmodule

// File: rtl/dtod_tod_accum.sv
module dtod_tod_accum
    import dtod_pkg::*;
#(
    parameter int FRAC_W        = 16,
    parameter int TICKS_PER_SEC = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  sfx_t        step,
    input  sfx_t        freq_eff,
    output logic [31:0] sec,
    output fx_t         nsf
);
    localparam int  TPS_LOG2 = $clog2(TICKS_PER_SEC);
    localparam fx_t NOM      = nominal_inc(FRAC_W, TICKS_PER_SEC);
    localparam fx_t WRAP     = NS_PER_SEC << FRAC_W;

    sfx_t   inc, adv;
    stamp_t nxt;
    logic   roll;

    always_comb begin
        adv  = inc + step;
        if (adv[63]) adv = '0;
        nxt  = carry_sec('{sec: sec, nsf: nsf + fx_t'(adv)}, WRAP);
        roll = (nxt.sec != sec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec <= '0;
            nsf <= '0;
            inc <= sfx_t'(NOM);
        end else if (tick) begin
            sec <= nxt.sec;
            nsf <= nxt.nsf;
            if (roll) inc <= sfx_t'(NOM) + (freq_eff >>> TPS_LOG2);
        end
    end

    p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
        nsf < WRAP);
    p_sec_step_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sec == $past(sec) || sec == $past(sec) + 32'd1));
    p_inc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(tick && roll) |=> $stable(inc));
    p_no_backstep_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sec != $past(sec) || nsf >= $past(nsf)));
endmodule

// File: rtl/dtod_read_port.sv
module dtod_read_port
    import dtod_pkg::*;
#(
    parameter int FRAC_W        = 16,
    parameter int TICKS_PER_SEC = 1024,
    parameter int TICK_CYCLES   = 8,
    parameter int CNT_W         = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [31:0]      sec,
    input  fx_t              nsf,
    input  logic [CNT_W-1:0] cnt,
    output logic             rd_valid,
    output stamp_t           rd
);
    localparam fx_t WRAP    = NS_PER_SEC << FRAC_W;
    localparam fx_t CYC_INC = nominal_inc(FRAC_W, TICKS_PER_SEC) / fx_t'(TICK_CYCLES);

    stamp_t cand, pick;

    always_comb begin
        cand = carry_sec('{sec: sec, nsf: nsf + fx_t'(cnt) * CYC_INC}, WRAP);
        pick = (cand < rd) ? rd : cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd       <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd <= pick;
        end
    end

    p_rd_lat_r7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    p_rd_mono_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd >= $past(rd)));
endmodule

// File: rtl/disc_tod_counter.sv
module disc_tod_counter
    import dtod_pkg::*;
#(
    parameter int FRAC_W        = 16,
    parameter int TICKS_PER_SEC = 1024,
    parameter int TICK_CYCLES   = 8,
    parameter int PHASE_W       = 29,
    parameter int SHIFT_W       = 5,
    parameter int FREQ_W        = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_phase_en,
    input  logic signed [PHASE_W-1:0] wr_phase,
    input  logic [SHIFT_W-1:0]        wr_shift,
    input  logic                      wr_freq_en,
    input  logic signed [FREQ_W-1:0]  wr_freq,
    input  logic                      rd_req,
    output logic                      rd_valid,
    output logic [31:0]               rd_sec,
    output logic [29:0]               rd_ns,
    output logic [FRAC_W-1:0]         rd_frac
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    sfx_t             step, freq_eff;
    logic [31:0]      sec;
    fx_t              nsf;
    stamp_t           rd;

    dtod_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt)
    );

    dtod_slew_unit #(
        .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W), .FREQ_W(FREQ_W)
    ) u_slew (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_phase_en(wr_phase_en), .wr_phase(wr_phase), .wr_shift(wr_shift),
        .wr_freq_en(wr_freq_en), .wr_freq(wr_freq),
        .step(step), .freq_eff(freq_eff)
    );

    dtod_tod_accum #(.FRAC_W(FRAC_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_accum (
        .clk(clk), .rst(rst), .tick(tick), .step(step), .freq_eff(freq_eff),
        .sec(sec), .nsf(nsf)
    );

    dtod_read_port #(
        .FRAC_W(FRAC_W), .TICKS_PER_SEC(TICKS_PER_SEC),
        .TICK_CYCLES(TICK_CYCLES), .CNT_W(CNT_W)
    ) u_read (
        .clk(clk), .rst(rst), .rd_req(rd_req), .sec(sec), .nsf(nsf), .cnt(cnt),
        .rd_valid(rd_valid), .rd(rd)
    );

    assign rd_sec  = rd.sec;
    assign rd_ns   = rd.nsf[FRAC_W +: 30];
    assign rd_frac = rd.nsf[FRAC_W-1:0];
endmodule

// File: tb/tb_disc_tod_counter.sv
module tb_disc_tod_counter;
    localparam int  FRAC = 16;
    localparam int  TPS  = 1024;
    localparam int  TC   = 8;
    localparam longint WRAP = 64'd1000000000 << FRAC;
    localparam longint NOM  = WRAP / TPS;
    localparam longint CYC  = NOM / TC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_phase_en = 1'b0, wr_freq_en = 1'b0, rd_req = 1'b0;
    logic signed [28:0] wr_phase = '0;
    logic [4:0]         wr_shift = '0;
    logic signed [31:0] wr_freq  = '0;
    logic               rd_valid;
    logic [31:0]        rd_sec;
    logic [29:0]        rd_ns;
    logic [FRAC-1:0]    rd_frac;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    disc_tod_counter dut (
        .clk(clk), .rst(rst),
        .wr_phase_en(wr_phase_en), .wr_phase(wr_phase), .wr_shift(wr_shift),
        .wr_freq_en(wr_freq_en), .wr_freq(wr_freq),
        .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_sec(rd_sec), .rd_ns(rd_ns), .rd_frac(rd_frac)
    );

    // Arithmetic model of the requirements
    int     m_cnt;
    longint m_sec, m_nsf, m_q, m_fr, m_inc, m_pq, m_pf, l_sec, l_nsf;
    int     m_sh, m_psh;
    bit     m_php, m_frp;

    always @(posedge clk) begin
        longint c_sec, c_nsf, q_e, st, adv, f_e;
        int     s_e;
        if (rst) begin
            m_cnt = 0; m_sec = 0; m_nsf = 0; m_q = 0; m_fr = 0; m_inc = NOM;
            m_sh = 0; m_php = 0; m_frp = 0; l_sec = 0; l_nsf = 0;
        end else begin
            if (rd_req) begin                         // R7 interpolation, R8 clamp
                c_sec = m_sec; c_nsf = m_nsf + longint'(m_cnt) * CYC;
                if (c_nsf >= WRAP) begin c_nsf -= WRAP; c_sec += 1; end
                if (!(c_sec < l_sec || (c_sec == l_sec && c_nsf < l_nsf))) begin
                    l_sec = c_sec; l_nsf = c_nsf;
                end
            end
            if (m_cnt == TC - 1) begin                // R2 tick
                q_e = m_php ? m_pq : m_q;
                s_e = m_php ? m_psh : m_sh;
                f_e = m_frp ? m_pf : m_fr;
                st  = q_e >>> s_e;                    // R5
                adv = m_inc + st;
                if (adv < 0) adv = 0;                 // R9
                m_nsf += adv;
                if (m_nsf >= WRAP) begin              // R3, R4
                    m_nsf -= WRAP; m_sec += 1;
                    m_inc = NOM + (f_e >>> 10);
                end
                m_q = q_e - st; m_sh = s_e; m_fr = f_e;
                m_php = 0; m_frp = 0;
                m_cnt = 0;
            end else m_cnt++;
            if (wr_phase_en) begin m_php = 1; m_pq = longint'(wr_phase) <<< FRAC; m_psh = int'(wr_shift); end
            if (wr_freq_en)  begin m_frp = 1; m_pf = longint'(wr_freq); end
        end
    end

    longint p_sec = 0, p_nsf = 0;

    task automatic rd_once(input string tag);
        longint e_ns, e_fr;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        e_ns = l_nsf >> FRAC;
        e_fr = l_nsf & ((64'd1 << FRAC) - 1);
        n_tests++;
        if (!rd_valid || longint'(rd_sec) != l_sec || longint'(rd_ns) != e_ns
            || longint'(rd_frac) != e_fr) begin
            n_fail++;
            $display("FAIL %s: got v=%0d %0d s %0d ns %0d fr, expected %0d s %0d ns %0d fr",
                     tag, rd_valid, rd_sec, rd_ns, rd_frac, l_sec, e_ns, e_fr);
        end
        n_tests++;
        if (longint'(rd_sec) < p_sec ||
            (longint'(rd_sec) == p_sec && ((longint'(rd_ns) << FRAC) | longint'(rd_frac)) < p_nsf)) begin
            n_fail++;
            $display("FAIL R8: got %0d s %0d ns, expected at least %0d s nsf %0d",
                     rd_sec, rd_ns, p_sec, p_nsf);
        end
        p_sec = longint'(rd_sec);
        p_nsf = (longint'(rd_ns) << FRAC) | longint'(rd_frac);
    endtask

    task automatic idle_reads(input int cycles, input int every, input string tag);
        for (int i = 0; i < cycles; i++) begin
            if (i % every == 0) rd_once(tag);
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (rd_valid !== 1'b0) begin
            n_fail++; $display("FAIL R1: rd_valid got %0b expected 0 in reset", rd_valid);
        end
        rst = 1'b0;
        n_tests++;
        if (rd_valid !== 1'b0) begin
            n_fail++; $display("FAIL R1: rd_valid got %0b expected 0 after reset", rd_valid);
        end
        rd_once("R1");
        // R2/R7: every interpolation offset across several ticks
        for (int i = 0; i < 40; i++) rd_once("R7");
        idle_reads(20, 3, "R2");
        // R5/R6: positive phase, exponent 2, written mid-tick
        wr_phase = 29'sd5000; wr_shift = 5'd2; wr_phase_en = 1'b1;
        @(negedge clk); wr_phase_en = 1'b0;
        for (int i = 0; i < 48; i++) rd_once("R6");
        idle_reads(40, 5, "R5");
        // R9/R8: negative phase larger than one tick, exponent 0
        wr_phase = -29'sd2000000; wr_shift = 5'd0; wr_phase_en = 1'b1;
        @(negedge clk); wr_phase_en = 1'b0;
        for (int i = 0; i < 32; i++) rd_once("R9");
        // R4: +1024 ns/s, then cross the seconds rollover
        wr_freq = 32'sd67108864; wr_freq_en = 1'b1;
        wr_phase = 29'sd300; wr_shift = 5'd3; wr_phase_en = 1'b1;
        @(negedge clk); wr_freq_en = 1'b0; wr_phase_en = 1'b0;
        idle_reads(7900, 97, "R4");
        for (int i = 0; i < 400; i++) rd_once("R3");
        idle_reads(200, 9, "R4");
        // R4: negative offset, next rollover
        wr_freq = -32'sd1310720000; wr_freq_en = 1'b1;
        @(negedge clk); wr_freq_en = 1'b0;
        idle_reads(7800, 53, "R4");
        for (int i = 0; i < 400; i++) rd_once("R3");
        idle_reads(300, 7, "R4");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_fail++; n_tests++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule